// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-cycle processor core. On every rising clock edge it loads a new fetch address. There is no hold or stall input, so the counter advances on every cycle. The new address comes from one of three sources. The first is the sequential address, the current PC plus four. The second is a PC-relative branch target, taken when the decoder requests a branch and the register comparison reports equality. The third is an absolute jump address. The jump keeps the top four bits of the incremented PC and fills the rest from the instruction's target field, followed by two zero bits.

The decoder drives three flags: branch request, equality result and jump request. It also passes the 16-bit offset field and the 26-bit target field of the current instruction word. The current PC goes to instruction memory. The incremented PC is also brought out, for link writes and similar uses. Instruction memory, register compare, ALU and decode all sit outside this block.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_o` becomes 0x00000000 after that edge, whatever the other inputs are.
- R2: `pc_plus4_o` always equals `pc_o` + 4 modulo 2^32, combinationally, including the wrap from 0xFFFFFFFC to 0x00000000.
- R3: When `jmp_sel_i` is low and the branch is not taken (`br_sel_i` low or `eq_i` low), `pc_o` becomes the old `pc_o` + 4 after the edge.
- R4: When `br_sel_i` and `eq_i` are both high and `jmp_sel_i` is low, `pc_o` becomes old PC + 4 + (sign-extended `imm_i` shifted left by 2). `imm_i` bit 15 is the sign bit.
- R5: When `jmp_sel_i` is high, `pc_o` becomes {bits 31..28 of old PC + 4, `jtarget_i`[25:0], 2'b00}. `imm_i` and `eq_i` have no effect.
- R6: When `jmp_sel_i` is high together with a taken branch, the jump address is loaded.
- R7: The branch target addition wraps modulo 2^32 in both directions.
- R8: The jump region bits come from PC + 4, not from PC. They therefore differ when PC + 4 crosses a 256 MiB boundary.
- R9: There is no write enable: `pc_o` changes on every edge with default inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; PC loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_sel_i | input | 1 | Conditional branch requested by the decoder |
| eq_i | input | 1 | Compared registers are equal |
| jmp_sel_i | input | 1 | Absolute jump requested |
| imm_i | input | 16 | Signed word offset of a branch |
| jtarget_i | input | 26 | Word target field of a jump |
| pc_o | output | 32 | Current fetch address |
| pc_plus4_o | output | 32 | Current fetch address plus four |

## Verification
The bench walks the PC through forward and backward branches and through a jump with both selects high. A wrong priority would load the branch target, not 0x100. It also walks the PC across the 0x0FFFFFFC to 0x10000000 region boundary. A design that took the region bits from PC, not PC + 4, would jump to 0x00000014 where 0x10000014 is expected. It forces a backward branch below zero, to 0xFFFFFFFC, and a forward branch out of the top of the address space. These catch a missing sign extension or a truncated adder. A branch request with equality low, and equality high without a branch request, must both still give PC + 4. A reset issued together with a jump must still give zero.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned NPC_ADDR_W     = 32;
    localparam int unsigned NPC_IMM_W      = 16;
    localparam int unsigned NPC_TGT_W      = 26;
    localparam int unsigned NPC_STEP_BYTES = 4;

    typedef enum logic [1:0] {
        NXT_SEQ    = 2'd0,
        NXT_BRANCH = 2'd1,
        NXT_JUMP   = 2'd2
    } nxt_src_e;

    typedef struct packed {
        logic br_sel;
        logic eq;
        logic jmp_sel;
    } nxt_ctl_t;

    function automatic logic branch_taken(input nxt_ctl_t c);
        return c.br_sel & c.eq;
    endfunction

    function automatic nxt_src_e pick_source(input nxt_ctl_t c);
        if (c.jmp_sel)           return NXT_JUMP;
        else if (branch_taken(c)) return NXT_BRANCH;
        else                      return NXT_SEQ;
    endfunction

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int unsigned ADDR_W     = npc_pkg::NPC_ADDR_W,
    parameter int unsigned STEP_BYTES = npc_pkg::NPC_STEP_BYTES
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] pc_next_seq_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

    assign pc_next_seq_o = pc_i + STEP_V;

endmodule

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
    parameter int unsigned ADDR_W     = npc_pkg::NPC_ADDR_W,
    parameter int unsigned IMM_W      = npc_pkg::NPC_IMM_W,
    parameter int unsigned STEP_BYTES = npc_pkg::NPC_STEP_BYTES
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int unsigned SH    = $clog2(STEP_BYTES);
    localparam int unsigned EXT_W = ADDR_W - IMM_W - SH;

    logic [ADDR_W-1:0] byte_off;

    // sign extension and word scaling in one concatenation
    assign byte_off = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {SH{1'b0}}};
    // modulo 2^ADDR_W by width truncation
    assign target_o = base_i + byte_off;

    // R7
    always_comb begin
        branch_dir_chk: assert (imm_i[IMM_W-1] ? (target_o != base_i) || (byte_off == '0)
                                               : 1'b1);
    end

endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc #(
    parameter int unsigned ADDR_W     = npc_pkg::NPC_ADDR_W,
    parameter int unsigned TGT_W      = npc_pkg::NPC_TGT_W,
    parameter int unsigned STEP_BYTES = npc_pkg::NPC_STEP_BYTES
) (
    input  logic [ADDR_W-TGT_W-$clog2(STEP_BYTES)-1:0] region_i,
    input  logic [TGT_W-1:0]                           tgt_i,
    output logic [ADDR_W-1:0]                          target_o
);
    localparam int unsigned SH = $clog2(STEP_BYTES);

    assign target_o = {region_i, tgt_i, {SH{1'b0}}};

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int unsigned ADDR_W = npc_pkg::NPC_ADDR_W
) (
    input  nxt_ctl_t          ctl_i,
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [ADDR_W-1:0] br_i,
    input  logic [ADDR_W-1:0] jmp_i,
    output logic [ADDR_W-1:0] next_o,
    output nxt_src_e          src_o
);
    logic [ADDR_W-1:0] stage1;

    // first stage: sequential versus relative branch
    assign stage1 = branch_taken(ctl_i) ? br_i : seq_i;
    // second stage: the jump overrides whatever stage one chose
    assign next_o = ctl_i.jmp_sel ? jmp_i : stage1;
    assign src_o  = pick_source(ctl_i);

    // R6
    always_comb begin
        jump_wins_chk: assert (!ctl_i.jmp_sel || next_o == jmp_i);
    end

    // R3
    always_comb begin
        seq_default_chk: assert (src_o != NXT_SEQ || next_o == seq_i);
    end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
    import npc_pkg::*;
#(
    parameter int unsigned ADDR_W     = npc_pkg::NPC_ADDR_W,
    parameter int unsigned IMM_W      = npc_pkg::NPC_IMM_W,
    parameter int unsigned TGT_W      = npc_pkg::NPC_TGT_W,
    parameter int unsigned STEP_BYTES = npc_pkg::NPC_STEP_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_sel_i,
    input  logic              eq_i,
    input  logic              jmp_sel_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [TGT_W-1:0]  jtarget_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus4_o
);
    localparam int unsigned SH    = $clog2(STEP_BYTES);
    localparam int unsigned REG_W = ADDR_W - TGT_W - SH;
    localparam int unsigned EXT_W = ADDR_W - IMM_W - SH;
    localparam logic [ADDR_W-1:0] RESET_PC = '0;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] next_pc;
    nxt_ctl_t          ctl;
    nxt_src_e          src;

    assign ctl = '{br_sel: br_sel_i, eq: eq_i, jmp_sel: jmp_sel_i};

    npc_incr #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) u_incr (
        .pc_i          (pc_q),
        .pc_next_seq_o (seq_addr)
    );

    npc_branch_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .STEP_BYTES(STEP_BYTES)) u_branch (
        .base_i   (seq_addr),
        .imm_i    (imm_i),
        .target_o (br_addr)
    );

    npc_jump_calc #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .STEP_BYTES(STEP_BYTES)) u_jump (
        .region_i (seq_addr[ADDR_W-1 -: REG_W]),
        .tgt_i    (jtarget_i),
        .target_o (jmp_addr)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_select (
        .ctl_i  (ctl),
        .seq_i  (seq_addr),
        .br_i   (br_addr),
        .jmp_i  (jmp_addr),
        .next_o (next_pc),
        .src_o  (src)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= next_pc;
    end

    assign pc_o       = pc_q;
    assign pc_plus4_o = seq_addr;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> pc_o == '0);

    // R2
    incr_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_plus4_o - pc_o) == ADDR_W'(STEP_BYTES));

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!jmp_sel_i && !(br_sel_i && eq_i)) |=> pc_o == $past(pc_plus4_o));

    // R4
    branch_off_chk: assert property (@(posedge clk) disable iff (rst)
        (br_sel_i && eq_i && !jmp_sel_i) |=>
        (pc_o - $past(pc_plus4_o)) ==
        {{EXT_W{$past(imm_i[IMM_W-1])}}, $past(imm_i), {SH{1'b0}}});

    // R5
    jump_field_chk: assert property (@(posedge clk) disable iff (rst)
        jmp_sel_i |=> pc_o[ADDR_W-REG_W-1:SH] == $past(jtarget_i) && pc_o[SH-1:0] == '0);

    // R8
    jump_region_chk: assert property (@(posedge clk) disable iff (rst)
        jmp_sel_i |=> pc_o[ADDR_W-1 -: REG_W] == $past(pc_plus4_o[ADDR_W-1 -: REG_W]));

    // R6
    jump_src_chk: assert property (@(posedge clk) disable iff (rst)
        jmp_sel_i |-> src == NXT_JUMP);

endmodule

// File: tb/next_pc_unit_bench.sv
`timescale 1ns/1ps
module next_pc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel_i = 1'b0;
    logic        eq_i = 1'b0;
    logic        jmp_sel_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [25:0] jtarget_i = '0;
    logic [31:0] pc_o;
    logic [31:0] pc_plus4_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    next_pc_unit u_next_pc_unit (
        .clk        (clk),
        .rst        (rst),
        .br_sel_i   (br_sel_i),
        .eq_i       (eq_i),
        .jmp_sel_i  (jmp_sel_i),
        .imm_i      (imm_i),
        .jtarget_i  (jtarget_i),
        .pc_o       (pc_o),
        .pc_plus4_o (pc_plus4_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic br, input logic eq, input logic jmp,
                         input logic [15:0] imm, input logic [25:0] tgt);
        br_sel_i  = br;
        eq_i      = eq;
        jmp_sel_i = jmp;
        imm_i     = imm;
        jtarget_i = tgt;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        tick();
        tick();
        check("R1 reset pc", pc_o, 32'h0000_0000);
        check("R2 reset pc+4", pc_plus4_o, 32'h0000_0004);
        rst = 1'b0;
    endtask

    task automatic t_sequential();
        drive(1'b0, 1'b0, 1'b0, 16'h0040, 26'h0000123);
        tick(); check("R9 step 1", pc_o, 32'h0000_0004);
        tick(); check("R9 step 2", pc_o, 32'h0000_0008);
        tick(); check("R3 step 3", pc_o, 32'h0000_000C);
        drive(1'b1, 1'b0, 1'b0, 16'h0040, '0);
        tick(); check("R3 branch not equal", pc_o, 32'h0000_0010);
        drive(1'b0, 1'b1, 1'b0, 16'h0040, '0);
        tick(); check("R3 equal without branch", pc_o, 32'h0000_0014);
    endtask

    task automatic t_branch();
        drive(1'b1, 1'b1, 1'b0, 16'h0005, '0);
        tick(); check("R4 forward branch", pc_o, 32'h0000_002C);
        check("R2 pc+4 after branch", pc_plus4_o, 32'h0000_0030);
        drive(1'b1, 1'b1, 1'b0, 16'hFFFD, '0);
        tick(); check("R4 backward branch", pc_o, 32'h0000_0024);
    endtask

    task automatic t_jump();
        drive(1'b0, 1'b1, 1'b1, 16'hFFFF, 26'h0000123);
        tick(); check("R5 jump", pc_o, 32'h0000_048C);
        drive(1'b1, 1'b1, 1'b1, 16'h0010, 26'h0000040);
        tick(); check("R6 jump beats branch", pc_o, 32'h0000_0100);
    endtask

    task automatic t_region();
        drive(1'b0, 1'b0, 1'b1, '0, 26'h3FF_FFFF);
        tick(); check("R5 jump to region top", pc_o, 32'h0FFF_FFFC);
        check("R2 pc+4 crosses region", pc_plus4_o, 32'h1000_0000);
        drive(1'b0, 1'b0, 1'b1, '0, 26'h0000005);
        tick(); check("R8 region from pc+4", pc_o, 32'h1000_0014);
    endtask

    task automatic t_wrap();
        t_reset();
        drive(1'b1, 1'b1, 1'b0, 16'hFFFE, '0);
        tick(); check("R7 branch below zero", pc_o, 32'hFFFF_FFFC);
        check("R2 pc+4 wraps", pc_plus4_o, 32'h0000_0000);
        drive(1'b1, 1'b1, 1'b0, 16'h0003, '0);
        tick(); check("R7 branch past top", pc_o, 32'h0000_000C);
    endtask

    task automatic t_reset_override();
        drive(1'b1, 1'b1, 1'b1, 16'h0100, 26'h0001000);
        rst = 1'b1;
        tick(); check("R1 reset beats jump", pc_o, 32'h0000_0000);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        tick(); check("R3 after reset", pc_o, 32'h0000_0004);
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_branch();
        t_jump();
        t_region();
        t_wrap();
        t_reset_override();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule